// File: doc/BRIEF.md
# Per-Second Line Performance Monitor

This block grades every one-second interval of a T1 line and keeps four saturating counters: errored seconds, severely errored seconds, bursty errored seconds and unavailable seconds. A one-cycle tick marks the end of each second. On that tick the block samples the second's error summary. This is the CRC-6 error count for the second, plus flags for a frame bit error, an out-of-frame event and a controlled slip. It also samples two alarm levels, AIS and carrier loss, at the same tick.

The block tracks whether the line is available or unavailable. A run of severe seconds makes the line unavailable, and the counts for that run are corrected backwards: the run's seconds move from the errored and severe counters into the unavailable counter. A run of non-severe seconds ends the unavailable state. The errored seconds seen during that clearing run were held aside, and on exit they are returned to the errored counter.

Software or a supervising engine reads any counter through a one-port read interface. The read can optionally clear the counter. All counter changes that belong to one second take effect together on the tick edge.

Top module: `perf_second_monitor`

## Requirements
- R1: A second is errored when its CRC-6 count is non-zero, or when a frame bit error, an out-of-frame event or a controlled slip is flagged.
- R2: A second is severely errored when it carries an out-of-frame event or at least SES_CRC_LIM (320) CRC-6 errors.
- R3: A second is bursty errored when its CRC-6 count is at least BES_CRC_MIN (2) and the second is not severely errored. A severe second never adds to the bursty counter.
- R4: In the available state, the ENTRY_RUN-th (10th) consecutive severe second makes the state unavailable. On that tick the unavailable counter rises by ENTRY_RUN, and the errored and severe counters each take a net change of 1 − ENTRY_RUN. `unavail_o` is high after that edge.
- R5: While the state is unavailable, no second adds to the errored, severe or bursty counters. Every second adds one to the unavailable counter.
- R6: While the state is unavailable, a hidden tally counts the errored seconds in the current run of non-severe seconds. A severe second or an alarm second resets both the run and the tally.
- R7: The EXIT_RUN-th (10th) consecutive non-severe second returns the state to available. On that tick the unavailable counter takes a net change of 1 − EXIT_RUN, and the errored counter gains the tally including that second. `unavail_o` is low after that edge.
- R8: A second with AIS or carrier loss adds one to the unavailable counter. In the available state, such a second adds nothing to the other counters and resets the severe run.
- R9: Every counter saturates at 2^CNT_W − 1 and never wraps.
- R10: A net decrease never takes a counter below zero. The result is clamped at zero.
- R11: `rd_sel` selects the counter: 0 = errored, 1 = severe, 2 = bursty, 3 = unavailable. With RD_LATENCY = 1, `rd_data` shows the counter's value from before the `rd_en` edge, one cycle after `rd_en`. With `rd_clr` set, the counter is zero after that edge.
- R12: Counters change only on a tick or a clear. When a clear and a tick hit the same counter on the same edge, the counter ends at that second's net update applied to zero.
- R13: After reset all counters read zero and the state is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse closing the current second |
| crc_errs | input | CRC_W | CRC-6 error count of the closing second |
| frm_bit_err | input | 1 | Frame bit error seen in the second |
| oof_evt | input | 1 | Out-of-frame event seen in the second |
| ctrl_slip | input | 1 | Controlled slip seen in the second |
| ais_alarm | input | 1 | AIS alarm level |
| carrier_loss | input | 1 | Carrier loss alarm level |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Counter select (R11 encoding) |
| rd_clr | input | 1 | Clear the selected counter with this read |
| rd_data | output | CNT_W | Read data |
| unavail_o | output | 1 | High while the line is unavailable |

## Verification
The bench builds the block with CNT_W = 8 and keeps the other parameters at their defaults: a 320-error severe threshold, runs of ten, and a registered read. The narrow counter lets a few hundred ticks reach the saturation ceiling. The full-width thresholds and run lengths keep the entry, exit and run-break corner cases at their real values. The bench clears a counter partway through a severe run so that the entry correction has to clamp at zero, and it lands a clear on the same edge as a tick.

// File: rtl/psm_pkg.sv
package psm_pkg;
   localparam int NUM_CNT = 4;

   typedef enum logic [1:0] {
      CNT_ES  = 2'd0,
      CNT_SES = 2'd1,
      CNT_BES = 2'd2,
      CNT_UAS = 2'd3
   } cnt_sel_e;
endpackage

// File: rtl/psm_classify.sv
module psm_classify #(
   parameter int CRC_W       = 9,
   parameter int SES_CRC_LIM = 320,
   parameter int BES_CRC_MIN = 2
) (
   input  logic [CRC_W-1:0] crc_i,
   input  logic             fbe_i,
   input  logic             oof_i,
   input  logic             slip_i,
   input  logic             ais_i,
   input  logic             rcl_i,
   output logic             es_o,
   output logic             ses_o,
   output logic             bes_o,
   output logic             alarm_o
);
   localparam logic [CRC_W-1:0] SES_LIM = CRC_W'(SES_CRC_LIM);
   localparam logic [CRC_W-1:0] BES_MIN = CRC_W'(BES_CRC_MIN);

   if ((SES_CRC_LIM >> CRC_W) != 0) begin : g_bad_crc_w
      $error("CRC_W too narrow for SES_CRC_LIM");
   end
   if (BES_CRC_MIN < 1 || BES_CRC_MIN >= SES_CRC_LIM) begin : g_bad_bes
      $error("BES_CRC_MIN must lie below SES_CRC_LIM");
   end

   always_comb begin
      es_o    = (crc_i != '0) || fbe_i || oof_i || slip_i;
      ses_o   = oof_i || (crc_i >= SES_LIM);
      bes_o   = (crc_i >= BES_MIN) && !ses_o;
      alarm_o = ais_i || rcl_i;
   end
endmodule

// File: rtl/psm_avail_fsm.sv
module psm_avail_fsm
   import psm_pkg::*;
#(
   parameter int ENTRY_RUN = 10,
   parameter int EXIT_RUN  = 10,
   parameter int RUN_W     = 4,
   parameter int DW        = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 es_i,
   input  logic                 ses_i,
   input  logic                 bes_i,
   input  logic                 alarm_i,
   output logic                 unavail_o,
   output logic [RUN_W-1:0]     run_len_o,
   output logic signed [DW-1:0] delta_o [NUM_CNT]
);
   localparam logic [RUN_W-1:0]     ENTRY_LAST  = RUN_W'(ENTRY_RUN - 1);
   localparam logic [RUN_W-1:0]     EXIT_LAST   = RUN_W'(EXIT_RUN - 1);
   localparam logic signed [DW-1:0] D_ONE       = DW'(1);
   localparam logic signed [DW-1:0] D_ENTRY     = DW'(ENTRY_RUN);
   localparam logic signed [DW-1:0] D_ENTRY_NET = DW'(1 - ENTRY_RUN);
   localparam logic signed [DW-1:0] D_EXIT_NET  = DW'(1 - EXIT_RUN);

   if (ENTRY_RUN < 1 || EXIT_RUN < 1) begin : g_bad_run
      $error("run lengths must be at least one");
   end

   logic             st_q, st_d;
   logic [RUN_W-1:0] run_q, run_d;
   logic [RUN_W-1:0] hid_q, hid_d;
   logic [RUN_W-1:0] hid_sum;

   assign hid_sum = hid_q + RUN_W'(es_i);

   always_comb begin
      st_d  = st_q;
      run_d = run_q;
      hid_d = hid_q;
      for (int k = 0; k < NUM_CNT; k++) delta_o[k] = '0;
      if (tick_i) begin
         if (!st_q) begin
            if (alarm_i) begin
               delta_o[CNT_UAS] = D_ONE;
               run_d            = '0;
            end else begin
               delta_o[CNT_ES]  = DW'(es_i);
               delta_o[CNT_SES] = DW'(ses_i);
               delta_o[CNT_BES] = DW'(bes_i);
               if (!ses_i) begin
                  run_d = '0;
               end else if (run_q == ENTRY_LAST) begin
                  st_d             = 1'b1;
                  run_d            = '0;
                  hid_d            = '0;
                  delta_o[CNT_UAS] = D_ENTRY;
                  delta_o[CNT_ES]  = D_ENTRY_NET;
                  delta_o[CNT_SES] = D_ENTRY_NET;
               end else begin
                  run_d = run_q + 1'b1;
               end
            end
         end else begin
            delta_o[CNT_UAS] = D_ONE;
            if (alarm_i || ses_i) begin
               run_d = '0;
               hid_d = '0;
            end else if (run_q == EXIT_LAST) begin
               st_d             = 1'b0;
               run_d            = '0;
               hid_d            = '0;
               delta_o[CNT_UAS] = D_EXIT_NET;
               delta_o[CNT_ES]  = DW'(hid_sum);
            end else begin
               run_d = run_q + 1'b1;
               hid_d = hid_sum;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= 1'b0;
         run_q <= '0;
         hid_q <= '0;
      end else begin
         st_q  <= st_d;
         run_q <= run_d;
         hid_q <= hid_d;
      end
   end

   assign unavail_o = st_q;
   assign run_len_o = run_q;
endmodule

// File: rtl/psm_sat_counter.sv
module psm_sat_counter #(
   parameter int CNT_W = 16,
   parameter int DW    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic signed [DW-1:0] delta_i,
   output logic [CNT_W-1:0]     cnt_o
);
   localparam int EW = CNT_W + 2;
   localparam logic signed [EW-1:0] TOP = {2'b00, {CNT_W{1'b1}}};

   if (DW >= EW) begin : g_bad_dw
      $error("delta width exceeds counter headroom");
   end

   logic [CNT_W-1:0]     cnt_q, cnt_d;
   logic signed [EW-1:0] base, dext, sum;

   always_comb begin
      base = clr_i ? '0 : signed'({2'b00, cnt_q});
      dext = EW'(delta_i);
      sum  = base + dext;
      if (sum < 0)        cnt_d = '0;
      else if (sum > TOP) cnt_d = '1;
      else                cnt_d = sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/perf_second_monitor.sv
module perf_second_monitor
   import psm_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int CRC_W       = 9,
   parameter int SES_CRC_LIM = 320,
   parameter int BES_CRC_MIN = 2,
   parameter int ENTRY_RUN   = 10,
   parameter int EXIT_RUN    = 10,
   parameter int RD_LATENCY  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_tick,
   input  logic [CRC_W-1:0] crc_errs,
   input  logic             frm_bit_err,
   input  logic             oof_evt,
   input  logic             ctrl_slip,
   input  logic             ais_alarm,
   input  logic             carrier_loss,
   input  logic             rd_en,
   input  logic [1:0]       rd_sel,
   input  logic             rd_clr,
   output logic [CNT_W-1:0] rd_data,
   output logic             unavail_o
);
   localparam int RUN_MAX = (ENTRY_RUN > EXIT_RUN) ? ENTRY_RUN : EXIT_RUN;
   localparam int RUN_W   = $clog2(RUN_MAX + 1);
   localparam int DW      = RUN_W + 2;

   if (RD_LATENCY != 0 && RD_LATENCY != 1) begin : g_bad_lat
      $error("RD_LATENCY must be 0 or 1");
   end

   logic                 es_flag, ses_flag, bes_flag, alarm_flag;
   logic [RUN_W-1:0]     run_len;
   logic signed [DW-1:0] delta [NUM_CNT];
   logic [CNT_W-1:0]     cnt_q [NUM_CNT];
   logic [NUM_CNT-1:0]   clr_hit;

   psm_classify #(
      .CRC_W(CRC_W), .SES_CRC_LIM(SES_CRC_LIM), .BES_CRC_MIN(BES_CRC_MIN)
   ) u_classify (
      .crc_i(crc_errs), .fbe_i(frm_bit_err), .oof_i(oof_evt), .slip_i(ctrl_slip),
      .ais_i(ais_alarm), .rcl_i(carrier_loss),
      .es_o(es_flag), .ses_o(ses_flag), .bes_o(bes_flag), .alarm_o(alarm_flag)
   );

   psm_avail_fsm #(
      .ENTRY_RUN(ENTRY_RUN), .EXIT_RUN(EXIT_RUN), .RUN_W(RUN_W), .DW(DW)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick_i(sec_tick),
      .es_i(es_flag), .ses_i(ses_flag), .bes_i(bes_flag), .alarm_i(alarm_flag),
      .unavail_o(unavail_o), .run_len_o(run_len), .delta_o(delta)
   );

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      assign clr_hit[k] = rd_en && rd_clr && (rd_sel == 2'(k));
      psm_sat_counter #(.CNT_W(CNT_W), .DW(DW)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr_i(clr_hit[k]),
         .delta_i(delta[k]), .cnt_o(cnt_q[k])
      );
   end

   if (RD_LATENCY == 0) begin : g_rd_comb
      assign rd_data = cnt_q[rd_sel];
   end else begin : g_rd_reg
      logic [CNT_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rd_q <= '0;
         else if (rd_en) rd_q <= cnt_q[rd_sel];
      end
      assign rd_data = rd_q;
   end
endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
   parameter int CNT_W     = 16,
   parameter int RUN_W     = 4,
   parameter int ENTRY_RUN = 10,
   parameter int EXIT_RUN  = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sec_tick,
   input logic             ses_now,
   input logic             alarm_now,
   input logic             unavail,
   input logic [RUN_W-1:0] run_len,
   input logic             rd_en,
   input logic             rd_clr,
   input logic [1:0]       rd_sel,
   input logic [CNT_W-1:0] cnt_es,
   input logic [CNT_W-1:0] cnt_ses,
   input logic [CNT_W-1:0] cnt_bes,
   input logic [CNT_W-1:0] cnt_uas
);
   logic any_clr;
   assign any_clr = rd_en && rd_clr;

   assert_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!unavail && sec_tick && ses_now && !alarm_now && run_len == RUN_W'(ENTRY_RUN - 1))
      |=> unavail);

   assert_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (unavail && sec_tick && !ses_now && !alarm_now && run_len == RUN_W'(EXIT_RUN - 1))
      |=> !unavail);

   assert_ses_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (unavail && !(any_clr && rd_sel == 2'd1)) |=> $stable(cnt_ses));

   assert_bes_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (unavail && !(any_clr && rd_sel == 2'd2)) |=> $stable(cnt_bes));

   assert_alarm_uas_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && alarm_now && !(any_clr && rd_sel == 2'd3) && cnt_uas != '1)
      |=> cnt_uas == $past(cnt_uas) + 1'b1);

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !any_clr)
      |=> ($stable(cnt_es) && $stable(cnt_ses) && $stable(cnt_bes) && $stable(cnt_uas)));

   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (any_clr && !sec_tick && rd_sel == 2'd0) |=> cnt_es == '0);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_bes == '1 && !(any_clr && rd_sel == 2'd2)) |=> cnt_bes == '1);
endmodule

bind perf_second_monitor psm_checker #(
   .CNT_W(CNT_W), .RUN_W(RUN_W), .ENTRY_RUN(ENTRY_RUN), .EXIT_RUN(EXIT_RUN)
) u_psm_checker (
   .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ses_now(ses_flag),
   .alarm_now(alarm_flag), .unavail(unavail_o), .run_len(run_len),
   .rd_en(rd_en), .rd_clr(rd_clr), .rd_sel(rd_sel),
   .cnt_es(cnt_q[0]), .cnt_ses(cnt_q[1]), .cnt_bes(cnt_q[2]), .cnt_uas(cnt_q[3])
);

// File: tb/perf_second_monitor_bench.sv
module perf_second_monitor_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW   = 8;
   localparam int TOPV = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sec_tick = 1'b0;
   logic [8:0]    crc_errs = '0;
   logic          frm_bit_err = 1'b0, oof_evt = 1'b0, ctrl_slip = 1'b0;
   logic          ais_alarm = 1'b0, carrier_loss = 1'b0;
   logic          rd_en = 1'b0, rd_clr = 1'b0;
   logic [1:0]    rd_sel = '0;
   logic [CW-1:0] rd_data;
   logic          unavail_o;

   perf_second_monitor #(.CNT_W(CW), .RD_LATENCY(1)) u_perf_second_monitor (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .crc_errs(crc_errs),
      .frm_bit_err(frm_bit_err), .oof_evt(oof_evt), .ctrl_slip(ctrl_slip),
      .ais_alarm(ais_alarm), .carrier_loss(carrier_loss), .rd_en(rd_en),
      .rd_sel(rd_sel), .rd_clr(rd_clr), .rd_data(rd_data), .unavail_o(unavail_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int    n_chk = 0, n_fail = 0;
   bit    done = 0;
   int    exp_q[$];
   string tag_q[$];
   int    m[4] = '{0, 0, 0, 0};
   bit    m_un = 0;
   int    m_run = 0, m_hid = 0;
   logic  due = 1'b0;

   function automatic int sat(int v);
      if (v < 0) return 0;
      if (v > TOPV) return TOPV;
      return v;
   endfunction

   // monitor: pops one expected read value per completed read
   always @(posedge clk) due <= rd_en;
   always @(negedge clk) begin
      if (due && exp_q.size() > 0) begin
         int    e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (int'(rd_data) != e) begin
            n_fail++;
            $display("FAIL %s: rd_data=%0d expected=%0d", t, rd_data, e);
         end
      end
   end

   // driver: one second, optionally with a same-edge read-and-clear
   task automatic sec(input int crc, input bit fbe, input bit oof, input bit slip,
                      input bit ais, input bit rcl, input int csel, input string tag);
      bit es, ses, bes, al;
      int dv[4];
      es  = (crc > 0) || fbe || oof || slip;
      ses = oof || (crc >= 320);
      bes = (crc >= 2) && !ses;
      al  = ais || rcl;
      dv  = '{0, 0, 0, 0};
      if (!m_un) begin
         if (al) begin dv[3] = 1; m_run = 0; end
         else begin
            dv[0] = int'(es); dv[1] = int'(ses); dv[2] = int'(bes);
            if (ses) begin
               m_run++;
               if (m_run == 10) begin
                  m_un = 1; m_run = 0; m_hid = 0;
                  dv[3] = 10; dv[0] = -9; dv[1] = -9;
               end
            end else m_run = 0;
         end
      end else begin
         dv[3] = 1;
         if (al || ses) begin m_run = 0; m_hid = 0; end
         else begin
            m_run++;
            m_hid += int'(es);
            if (m_run == 10) begin
               m_un = 0; m_run = 0; dv[3] = -9; dv[0] = m_hid; m_hid = 0;
            end
         end
      end
      @(negedge clk);
      sec_tick = 1'b1; crc_errs = 9'(crc); frm_bit_err = fbe; oof_evt = oof;
      ctrl_slip = slip; ais_alarm = ais; carrier_loss = rcl;
      if (csel >= 0) begin
         rd_en = 1'b1; rd_clr = 1'b1; rd_sel = 2'(csel);
         exp_q.push_back(m[csel]); tag_q.push_back(tag);
         m[csel] = 0;
      end
      for (int k = 0; k < 4; k++) m[k] = sat(m[k] + dv[k]);
      @(negedge clk);
      sec_tick = 1'b0; crc_errs = '0; frm_bit_err = 0; oof_evt = 0; ctrl_slip = 0;
      ais_alarm = 0; carrier_loss = 0; rd_en = 0; rd_clr = 0;
   endtask

   task automatic rd(input int sel, input bit clr, input string tag);
      @(negedge clk);
      rd_en = 1'b1; rd_clr = clr; rd_sel = 2'(sel);
      exp_q.push_back(m[sel]); tag_q.push_back(tag);
      if (clr) m[sel] = 0;
      @(negedge clk);
      rd_en = 1'b0; rd_clr = 1'b0;
   endtask

   task automatic chk_un(input string tag);
      n_chk++;
      if (unavail_o !== m_un) begin
         n_fail++;
         $display("FAIL %s: unavail_o=%0b expected=%0b", tag, unavail_o, m_un);
      end
   endtask

   task automatic t_crc(input int c);  sec(c, 0, 0, 0, 0, 0, -1, ""); endtask
   task automatic t_fbe();              sec(0, 1, 0, 0, 0, 0, -1, ""); endtask
   task automatic t_oof();              sec(0, 0, 1, 0, 0, 0, -1, ""); endtask
   task automatic t_clean();            sec(0, 0, 0, 0, 0, 0, -1, ""); endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R13 reset state
      chk_un("R13 state after reset");
      for (int k = 0; k < 4; k++) rd(k, 0, "R13 counter after reset");
      // R1 errored sources, R11 read with clear then plain read
      t_crc(1); t_fbe(); sec(0, 0, 0, 1, 0, 0, -1, "");
      rd(2, 0, "R3 single CRC error is not bursty");
      rd(0, 1, "R1 errored seconds from CRC, frame bit, slip");
      rd(0, 0, "R11 counter zero after clearing read");
      // R2 / R3 thresholds
      t_crc(2); t_crc(319); t_crc(320); sec(50, 0, 1, 0, 0, 0, -1, "");
      rd(2, 1, "R3 bursty for 2 and 319 errors only");
      rd(1, 1, "R2 severe for 320 errors and OOF");
      rd(0, 1, "R1 all four seconds errored");
      // R8 alarms in available state
      sec(400, 0, 0, 0, 1, 0, -1, ""); sec(0, 1, 0, 0, 0, 1, -1, "");
      rd(3, 1, "R8 alarm seconds counted unavailable");
      rd(0, 0, "R8 alarm seconds not errored");
      // alarm resets severe run: 9 severe, alarm, 9 severe stays available
      repeat (9) t_oof();
      sec(0, 0, 0, 0, 1, 0, -1, "");
      repeat (9) t_oof();
      chk_un("R8 alarm second broke the severe run");
      t_clean();
      rd(0, 1, "R1 errored before entry test"); rd(1, 1, "R2 severe before entry test");
      rd(3, 1, "R8 uas before entry test");
      // R4 entry
      repeat (3) t_fbe();
      repeat (9) t_oof();
      chk_un("R4 still available after nine severe");
      t_oof();
      chk_un("R4 unavailable after tenth severe");
      rd(0, 0, "R4 errored count backed out");
      rd(1, 0, "R4 severe count backed out");
      rd(3, 0, "R4 unavailable gained ten");
      // R5 inhibit, R6 run break, R7 exit
      t_oof(); t_crc(30);
      rd(1, 0, "R5 severe frozen while unavailable");
      rd(2, 0, "R5 bursty frozen while unavailable");
      repeat (3) t_fbe();
      t_oof();
      t_crc(5); t_crc(5);
      repeat (7) t_clean();
      chk_un("R6 run restarted after severe break");
      t_clean();
      chk_un("R7 available after ten clear seconds");
      rd(0, 0, "R7 held errored seconds returned");
      rd(3, 1, "R7 unavailable reduced by ten");
      rd(2, 0, "R5 bursty not restored on exit");
      // R10 floor: clear severe mid-run, entry correction clamps
      repeat (5) t_oof();
      rd(1, 1, "R2 partial severe run");
      rd(0, 1, "R1 partial run errored");
      repeat (5) t_oof();
      chk_un("R4 entry after run spanning a clear");
      rd(1, 0, "R10 severe clamped at zero");
      rd(0, 0, "R10 errored clamped at zero");
      repeat (10) t_clean();
      chk_un("R7 exit after clean run");
      // R12 clear on same edge as tick
      t_fbe(); t_fbe();
      sec(0, 1, 0, 0, 0, 0, 0, "R12 read value before same-edge clear");
      rd(0, 0, "R12 tick kept after same-edge clear");
      // R9 saturation
      repeat (300) t_crc(2);
      rd(2, 0, "R9 bursty saturates");
      rd(0, 0, "R9 errored saturates");
      t_crc(2);
      rd(2, 0, "R9 no wrap after more ticks");
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule